// File: doc/BRIEF.md
# Periodic Real-Time Interrupt Generator

This block divides the bus clock into a periodic real-time tick and turns each tick into a sticky interrupt flag. A two-bit rate field picks one of four periods. Each period is a base count times a power of two. A mask bit decides whether the flag drives the interrupt request line. Software polls or services the flag and clears it by writing a one to the flag bit.

Software may change the rate at any moment. A write to the control register reloads the period counter, so the next tick comes one full new period after that write. The write itself never raises the flag. Register access is a single-cycle write strobe with a separate combinational read port.

Top module: `rti_gen`

## Requirements
- R1: The tick period in clock cycles is BASE_PERIOD × 2^n. Here n is the rate field, bits [1:0] of the control register at address 0. With the default BASE_PERIOD of 8192 this gives 8192, 16384, 32768 or 65536 cycles.
- R2: On every period boundary the flag is set. The flag is bit 0 of the flag register at address 2. It stays set across later periods until it is cleared.
- R3: A write to address 2 with bit 0 equal to 1 clears the flag on that clock edge. A write there with bit 0 equal to 0 leaves the flag unchanged.
- R4: The irq output is high exactly when the flag is set and the enable is set. The enable is bit 0 of the mask register at address 1.
- R5: Any write to address 0 reloads the counter. The next boundary falls P(new) clock edges after the write edge. A boundary that was due on the write edge is cancelled, and the write never sets the flag.
- R6: Reset clears the rate field, the enable and the flag. After reset is released, the first boundary comes on the P(0)-th clock edge.
- R7: When a boundary and a write-1 clear of the flag fall on the same edge, the flag ends up set.
- R8: Register bits other than the rate field, the enable and the flag read as 0. Address 3 reads as 0, and writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | Write address: 0 control, 1 mask, 2 flag |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 8 | Combinational read data |
| irq | output | 1 | Interrupt request, flag gated by enable |

## Verification
Two cases are hard to reach from the ports. One is a write-1 clear that lands exactly on a period boundary. The other is a rate write that lands one edge before a boundary is due. The bench uses a small base period and counts edges from the most recent control write to aim each register write at the exact edge where these events meet. It then checks the flag on the edges just before and just after the expected boundary. Every rate is swept, with the enable alternating, and each rate is checked over two consecutive periods.

// File: rtl/rti_pkg.sv
package rti_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_MASK = 2'd1;
  localparam logic [ADDR_W-1:0] A_FLAG = 2'd2;

  // Period in cycles for a given rate code
  function automatic int unsigned period_cycles(int unsigned base, int unsigned rate);
    return base << rate;
  endfunction
endpackage

// File: rtl/rti_period_cnt.sv
module rti_period_cnt #(
  parameter int unsigned BASE_PERIOD = 8192,
  parameter int unsigned RATE_W      = 2,
  parameter int unsigned CNT_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [RATE_W-1:0] load_rate,
  input  logic [RATE_W-1:0] cur_rate,
  output logic [CNT_W-1:0]  cnt,
  output logic              tick
);
  import rti_pkg::*;

  function automatic logic [CNT_W-1:0] reload_of(logic [RATE_W-1:0] r);
    return CNT_W'(period_cycles(BASE_PERIOD, int'(r)) - 1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= reload_of('0);
    else if (load)        cnt <= reload_of(load_rate);
    else if (cnt == '0)   cnt <= reload_of(cur_rate);
    else                  cnt <= cnt - CNT_W'(1);
  end

  // Boundary: counter exhausted and not overridden by a reload
  assign tick = (cnt == '0) && !load;
endmodule

// File: rtl/rti_regs.sv
module rti_regs #(
  parameter int unsigned RATE_W = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [rti_pkg::ADDR_W-1:0] wr_addr,
  input  logic [rti_pkg::DATA_W-1:0] wr_data,
  input  logic [rti_pkg::ADDR_W-1:0] rd_addr,
  input  logic                       tick,
  output logic [rti_pkg::DATA_W-1:0] rd_data,
  output logic [RATE_W-1:0]          rate,
  output logic                       en,
  output logic                       flag,
  output logic                       rate_wr,
  output logic                       clr_req
);
  import rti_pkg::*;

  assign rate_wr = wr_en && (wr_addr == A_CTRL);
  assign clr_req = wr_en && (wr_addr == A_FLAG) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate <= '0;
      en   <= 1'b0;
      flag <= 1'b0;
    end else begin
      if (rate_wr) rate <= wr_data[RATE_W-1:0];
      if (wr_en && (wr_addr == A_MASK)) en <= wr_data[0];
      if (tick)         flag <= 1'b1;   // set has priority
      else if (clr_req) flag <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:  rd_data[RATE_W-1:0] = rate;
      A_MASK:  rd_data[0] = en;
      A_FLAG:  rd_data[0] = flag;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/rti_gen.sv
module rti_gen #(
  parameter int unsigned BASE_PERIOD = 8192,
  parameter int unsigned RATE_W      = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       irq
);
  localparam int unsigned MAX_PERIOD = BASE_PERIOD << ((1 << RATE_W) - 1);
  localparam int unsigned CNT_W      = $clog2(MAX_PERIOD);

  logic [RATE_W-1:0] rate;
  logic              en;
  logic              flag;
  logic              rate_wr;
  logic              clr_req;
  logic              tick;
  logic [CNT_W-1:0]  cnt;

  rti_period_cnt #(
    .BASE_PERIOD(BASE_PERIOD), .RATE_W(RATE_W), .CNT_W(CNT_W)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(rate_wr),
    .load_rate(wr_data[RATE_W-1:0]), .cur_rate(rate),
    .cnt(cnt), .tick(tick)
  );

  rti_regs #(.RATE_W(RATE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .tick(tick),
    .rd_data(rd_data), .rate(rate), .en(en), .flag(flag),
    .rate_wr(rate_wr), .clr_req(clr_req)
  );

  assign irq = flag & en;
endmodule

// File: rtl/rti_gen_chk.sv
module rti_gen_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             rate_wr,
  input logic             clr_req,
  input logic             flag,
  input logic             en,
  input logic             irq,
  input logic [CNT_W-1:0] cnt
);
  p_count_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rate_wr && cnt != '0) |=> cnt == $past(cnt) - CNT_W'(1));

  p_tick_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> flag);

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !tick) |=> !flag);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_req && !tick) |=> $stable(flag));

  p_mask_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !irq);

  p_write_no_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rate_wr |=> !$rose(flag));

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && clr_req) |=> flag);
endmodule

bind rti_gen rti_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .rate_wr(rate_wr),
  .clr_req(clr_req), .flag(flag), .en(en), .irq(irq), .cnt(cnt)
);

// File: tb/rti_gen_bench.sv
module rti_gen_bench;
  localparam int unsigned BASE = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  rti_gen #(.BASE_PERIOD(BASE), .RATE_W(2)) u_rti_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  function automatic int per(int n);
    return BASE * (1 << n);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  // Called at a negedge; the write lands on the next posedge
  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic chk_flag(string req, int exp);
    int v;
    rd(2'd2, v);
    chk(req, v, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int v;
    waitn(2);
    // R6: reset state
    rd(2'd0, v); chk("R6 ctrl", v, 0);
    rd(2'd1, v); chk("R6 mask", v, 0);
    chk_flag("R6 flag", 0);
    chk("R6 irq", int'(irq), 0);
    rst_n = 1'b1;
    waitn(BASE - 1); chk_flag("R6 before first boundary", 0);
    waitn(1);        chk_flag("R6 first boundary", 1);

    // R1/R2/R4: sweep every rate
    for (int n = 0; n < 4; n++) begin
      int en_v;
      en_v = n % 2;
      wr(2'd1, 8'(en_v));
      wr(2'd0, 8'(n));
      wr(2'd2, 8'h01);
      rd(2'd0, v); chk("R1 ctrl readback", v, n);
      waitn(per(n) - 2);
      chk_flag("R1 before boundary", 0);
      chk("R4 irq low", int'(irq), 0);
      waitn(1);
      chk_flag("R1 at boundary", 1);
      chk("R4 irq gated", int'(irq), en_v);
      wr(2'd2, 8'h01);
      chk_flag("R3 clear", 0);
      chk("R4 irq after clear", int'(irq), 0);
      waitn(per(n) - 2);
      chk_flag("R2 second period before", 0);
      waitn(1);
      chk_flag("R2 second period", 1);
    end

    // R3: writing 0 has no effect
    wr(2'd2, 8'h00);
    chk_flag("R3 write0 keeps", 1);
    chk("R4 irq stays", int'(irq), 1);

    // R7: clear on the boundary edge
    wr(2'd0, 8'd0);
    waitn(31);
    wr(2'd2, 8'h01);
    chk_flag("R7 set wins", 1);
    wr(2'd2, 8'h01);
    chk_flag("R3 clear after collision", 0);

    // R5: rate write one edge before a due boundary
    wr(2'd0, 8'd0);
    wr(2'd2, 8'h01);
    waitn(13);
    wr(2'd0, 8'd1);
    chk_flag("R5 no set on write", 0);
    waitn(1);
    chk_flag("R5 old boundary cancelled", 0);
    waitn(per(1) - 2);
    chk_flag("R5 before new boundary", 0);
    waitn(1);
    chk_flag("R5 new boundary", 1);

    // R8: unused bits and address 3
    wr(2'd0, 8'hFF);
    rd(2'd0, v); chk("R8 ctrl upper bits", v, 3);
    wr(2'd1, 8'hFE);
    rd(2'd1, v); chk("R8 mask upper bits", v, 0);
    wr(2'd1, 8'h01);
    wr(2'd3, 8'hFF);
    rd(2'd3, v); chk("R8 addr3 read", v, 0);
    rd(2'd0, v); chk("R8 ctrl unchanged", v, 3);
    rd(2'd1, v); chk("R8 mask unchanged", v, 1);
    chk_flag("R8 flag unchanged", 1);

    // R6: reset mid-run
    rst_n = 1'b0;
    waitn(1);
    rd(2'd0, v); chk("R6 ctrl after reset", v, 0);
    rd(2'd1, v); chk("R6 mask after reset", v, 0);
    chk_flag("R6 flag after reset", 0);
    chk("R6 irq after reset", int'(irq), 0);
    rst_n = 1'b1;
    waitn(BASE - 1); chk_flag("R6 restart before", 0);
    waitn(1);        chk_flag("R6 restart boundary", 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule